// File: doc/BRIEF.md
# Interrupt Event Latch and Mask Unit

This block gathers the interrupt events of a serial bus controller into one status word and drives a single interrupt line from it. Ten of the twelve sources arrive as one-cycle pulses and are held in sticky bits until software clears them. The other two, receive-buffer full and transmit-buffer empty, are level conditions that follow their inputs. A mask register selects which raw bits reach the masked status word. The OR of the masked word, registered once, is the interrupt output.

Software clears sticky bits by reading, not by writing. Each pulse source has its own clear address, and reading that address clears that one bit. A combined clear address clears every sticky bit at once. When a transmit abort is reported, a cause vector that comes with the pulse is accumulated into an abort-cause register. That register is emptied in the same cycle as the abort status bit is cleared. A transfer-start strobe loads the mask with the set of sources a transfer normally needs.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the raw status, mask, masked status and abort-cause registers read as zero, and `irq_o` is low.
- R2: A pulse on `evt_i[i]` sets sticky raw status bit i for every source other than bits 2 and 4. The raw status is read at address 0. Bit order: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R3: Raw bit 2 always equals `rx_full_i` and raw bit 4 always equals `tx_empty_i`. Pulses on `evt_i[2]` or `evt_i[4]` have no effect on them, and no clear read affects them.
- R4: The mask is written at address 1 and read back there. The masked status read at address 2 always equals the raw status ANDed with the mask.
- R5: `irq_o` is high in the cycle after the masked status is non-zero, and low in the cycle after it is zero.
- R6: A read of address 16+i, for a pulse source i, clears raw bit i only and returns zero.
- R7: A read of address 4 clears all sticky raw bits and the abort-cause register.
- R8: An event pulse in the same cycle as a clear read of that bit wins, and the bit stays set. The same holds for a new abort cause arriving in the cycle the abort-cause register is cleared.
- R9: On a tx-abort pulse (`evt_i[6]`), `abort_cause_i` is ORed into the abort-cause register, which is read at address 3. Cause bits: 0 7-bit address not acknowledged, 1 and 2 10-bit address bytes not acknowledged, 3 data not acknowledged, 4 general call not acknowledged, 5 read after general call, 7 start byte acknowledged, 9 and 10 restart-disabled violations, 11 master disabled, 12 arbitration lost.
- R10: A read of address 22 (the tx-abort clear) clears raw bit 6 and the abort-cause register together.
- R11: A pulse on `xfer_start_i` loads the mask with 0x254 (bits 2, 4, 6, 9). It takes priority over a mask write in the same cycle.
- R12: Writes to any address other than 1 change nothing. Reads of addresses 0 to 3 clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 12 | One-cycle event pulses, one per source |
| rx_full_i | input | 1 | Receive-buffer full level |
| tx_empty_i | input | 1 | Transmit-buffer empty level |
| abort_cause_i | input | 13 | Abort cause vector, valid with `evt_i[6]` |
| xfer_start_i | input | 1 | Loads the transfer mask |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (5) | Register word address |
| wdata_i | input | DATA_W (16) | Write data |
| rdata_o | output | DATA_W (16) | Read data, one cycle after `rd_en_i` |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its default widths: a 5-bit address and 16-bit data. This puts every per-source clear address, the combined clear and the full 13-bit abort vector on the port. A table of event patterns and masks checks how sticky latching and masking combine. Directed tests then cover the level sources held against clear reads, a clear colliding with a new pulse, abort causes accumulating and then being emptied, and the transfer-start mask taking priority over a write.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int NUM_SRC = 12;
    localparam int ABRT_W  = 13;

    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 4;
    localparam int SRC_TX_ABRT  = 6;

    // sources that are levels, not sticky pulses
    localparam logic [NUM_SRC-1:0] LEVEL_SRCS   = 12'h014;
    // mask loaded when a transfer starts
    localparam logic [NUM_SRC-1:0] XFER_MASK    = 12'h254;

    // register word addresses
    localparam int A_RAW      = 0;
    localparam int A_MASK     = 1;
    localparam int A_STAT     = 2;
    localparam int A_ABRT     = 3;
    localparam int A_CLR_ALL  = 4;
    localparam int A_CLR_BASE = 16;

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;  // sticky bits to clear this cycle
        logic               cause; // empty the abort-cause register
    } clr_req_t;

    function automatic logic is_level(input int idx);
        return LEVEL_SRCS[idx];
    endfunction

endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import irq_status_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] lat_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (is_level(i)) begin : g_level
            assign lat_o[i] = 1'b0;
        end else begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)             bit_q <= 1'b0;
                else if (evt_i[i])   bit_q <= 1'b1;  // event beats clear
                else if (clr_i[i])   bit_q <= 1'b0;
            end
            assign lat_o[i] = bit_q;

            // R8 / R2: a pulse always leaves the bit set
            a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
                evt_i[i] |=> lat_o[i]);
            // R6: a clear without a pulse drops the bit
            a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
                (clr_i[i] && !evt_i[i]) |=> !lat_o[i]);
        end
    end

endmodule

// File: rtl/irq_abort_capture.sv
module irq_abort_capture
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_evt_i,
    input  logic [ABRT_W-1:0] cause_i,
    input  logic              clr_i,
    output logic [ABRT_W-1:0] cause_o
);

    logic [ABRT_W-1:0] cause_q;
    logic [ABRT_W-1:0] kept;

    always_comb begin
        kept = clr_i ? '0 : cause_q;
        if (abort_evt_i) kept = kept | cause_i;
    end

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= kept;
    end

    assign cause_o = cause_q;

    // R10: clearing without a new abort empties the register
    a_r10_cause_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !abort_evt_i) |=> (cause_o == '0));
    // R9: every reported cause bit is present afterwards
    a_r9_cause_held: assert property (@(posedge clk) disable iff (rst)
        abort_evt_i |=> ((cause_o & $past(cause_i)) == $past(cause_i)));

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               xfer_start_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] stat_i,
    input  logic [ABRT_W-1:0]  cause_i,
    output logic [NUM_SRC-1:0] mask_o,
    output clr_req_t           clr_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam logic [ADDR_W-1:0] AD_RAW  = ADDR_W'(A_RAW);
    localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_MASK);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_ABRT = ADDR_W'(A_ABRT);
    localparam logic [ADDR_W-1:0] AD_CALL = ADDR_W'(A_CLR_ALL);

    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  rd_next;
    logic               clr_all;

    assign clr_all = rd_en_i && (addr_i == AD_CALL);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        localparam logic [ADDR_W-1:0] AD_ONE = ADDR_W'(A_CLR_BASE + i);
        if (is_level(i)) begin : g_none
            assign clr_o.bits[i] = 1'b0;
        end else begin : g_dec
            assign clr_o.bits[i] = clr_all || (rd_en_i && addr_i == AD_ONE);
        end
    end
    assign clr_o.cause = clr_o.bits[SRC_TX_ABRT];

    always_ff @(posedge clk) begin
        if (rst)                                  mask_q <= '0;
        else if (xfer_start_i)                    mask_q <= XFER_MASK;
        else if (wr_en_i && addr_i == AD_MASK)    mask_q <= wdata_i[NUM_SRC-1:0];
    end
    assign mask_o = mask_q;

    always_comb begin
        rd_next = '0;
        if      (addr_i == AD_RAW)  rd_next = DATA_W'(raw_i);
        else if (addr_i == AD_MASK) rd_next = DATA_W'(mask_q);
        else if (addr_i == AD_STAT) rd_next = DATA_W'(stat_i);
        else if (addr_i == AD_ABRT) rd_next = DATA_W'(cause_i);
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_next;
    end

    // R6: outside the combined clear at most one bit is cleared
    a_r6_single_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i != AD_CALL) |-> $onehot0(clr_o.bits));
    // R12: no read strobe, no clear
    a_r12_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |-> (clr_o.bits == '0 && !clr_o.cause));
    // R11: transfer start loads the fixed mask
    a_r11_xfer_mask: assert property (@(posedge clk) disable iff (rst)
        xfer_start_i |=> (mask_o == XFER_MASK));

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               rx_full_i,
    input  logic               tx_empty_i,
    input  logic [ABRT_W-1:0]  abort_cause_i,
    input  logic               xfer_start_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] lat;
    logic [NUM_SRC-1:0] lvl;
    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] stat;
    logic [ABRT_W-1:0]  cause;
    clr_req_t           clr;

    always_comb begin
        lvl               = '0;
        lvl[SRC_RX_FULL]  = rx_full_i;
        lvl[SRC_TX_EMPTY] = tx_empty_i;
    end

    assign raw  = lat | lvl;
    assign stat = raw & mask;

    irq_latch_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .clr_i (clr.bits),
        .lat_o (lat)
    );

    irq_abort_capture u_abort (
        .clk         (clk),
        .rst         (rst),
        .abort_evt_i (evt_i[SRC_TX_ABRT]),
        .cause_i     (abort_cause_i),
        .clr_i       (clr.cause),
        .cause_o     (cause)
    );

    irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk          (clk),
        .rst          (rst),
        .rd_en_i      (rd_en_i),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .xfer_start_i (xfer_start_i),
        .raw_i        (raw),
        .stat_i       (stat),
        .cause_i      (cause),
        .mask_o       (mask),
        .clr_o        (clr),
        .rdata_o      (rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |stat;
    end

    // R5: line follows the masked word one cycle later
    a_r5_irq_rise: assert property (@(posedge clk) disable iff (rst)
        (|stat) |=> irq_o);
    a_r5_irq_fall: assert property (@(posedge clk) disable iff (rst)
        !(|stat) |=> !irq_o);
    // R3: level sources track their inputs
    a_r3_level_track: assert property (@(posedge clk) disable iff (rst)
        (raw[SRC_RX_FULL] == rx_full_i) && (raw[SRC_TX_EMPTY] == tx_empty_i));

endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] evt;
    logic        rx_full, tx_empty;
    logic [12:0] cause;
    logic        xstart, rd_en, wr_en;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_unit u_dut (
        .clk(clk), .rst(rst), .evt_i(evt), .rx_full_i(rx_full),
        .tx_empty_i(tx_empty), .abort_cause_i(cause), .xfer_start_i(xstart),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // {event pattern, mask, expected masked status}
    localparam logic [35:0] VEC [NV] = '{
        {12'hFFF, 12'hFFF, 12'hFEB},
        {12'h0C1, 12'h041, 12'h041},
        {12'hA50, 12'hF0F, 12'hA00},
        {12'h300, 12'h000, 12'h000},
        {12'h808, 12'h8FF, 12'h808},
        {12'h123, 12'h0F0, 12'h020}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = 5'(a);
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] e, input logic [12:0] c);
        @(negedge clk); evt = e; cause = c;
        @(negedge clk); evt = '0; cause = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        rst = 1'b1; evt = '0; rx_full = 0; tx_empty = 0; cause = '0;
        xstart = 0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, d); chk("R1 raw", d, 16'h0);
        rd(1, d); chk("R1 mask", d, 16'h0);
        rd(2, d); chk("R1 stat", d, 16'h0);
        rd(3, d); chk("R1 abort", d, 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);

        // R2 R4 R5 table walk
        for (int v = 0; v < NV; v++) begin
            rd(4, d);
            wr(1, 16'(VEC[v][23:12]));
            pulse(VEC[v][35:24], 13'h0);
            rd(2, d); chk("R4 masked status", d, 16'(VEC[v][11:0]));
            @(negedge clk);
            chk("R5 irq", 16'(irq), 16'(|VEC[v][11:0]));
        end
        rd(1, d); chk("R4 mask readback", d, 16'h0F0);

        // R6 single clear
        rd(4, d);
        pulse(12'hFFF, 13'h0);
        rd(25, d); chk("R6 clear returns zero", d, 16'h0);
        rd(0, d); chk("R6 one bit cleared", d, 16'hDEB);

        // R3 level sources
        rd(18, d); rd(0, d); chk("R3 level clear ignored", d, 16'hDEB);
        rx_full = 1; tx_empty = 1;
        rd(4, d);
        rd(0, d); chk("R3 level held across combined clear", d, 16'h014);
        rd(20, d); rd(0, d); chk("R3 tx empty clear read ignored", d, 16'h014);
        rx_full = 0; tx_empty = 0;
        rd(0, d); chk("R3 levels follow inputs", d, 16'h000);
        chk("R7 combined clear", d, 16'h000);

        // R8 event wins over clear
        @(negedge clk); evt = 12'h200; rd_en = 1; addr = 5'd25;
        @(negedge clk); evt = '0; rd_en = 0;
        rd(0, d); chk("R8 event beats clear", d, 16'h200);
        rd(4, d);

        // R12 ignored accesses
        wr(0, 16'hFFFF); wr(2, 16'hFFFF); wr(3, 16'hFFFF);
        pulse(12'h001, 13'h0);
        wr(25, 16'hFFFF);
        rd(0, d); rd(1, d); rd(2, d); rd(3, d);
        rd(0, d); chk("R12 no write or read side effect", d, 16'h001);
        rd(1, d); chk("R12 mask untouched", d, 16'h0F0);
        rd(4, d);

        // R9 abort cause accumulation
        pulse(12'h040, 13'h1009);
        pulse(12'h040, 13'h0002);
        rd(3, d); chk("R9 cause accumulates", d, 16'h100B);
        rd(0, d); chk("R9 abort bit set", d, 16'h040);

        // R10 abort clear
        rd(22, d);
        rd(3, d); chk("R10 cause emptied", d, 16'h0);
        rd(0, d); chk("R10 abort bit cleared", d, 16'h0);

        // R8 new abort during clear
        pulse(12'h040, 13'h0800);
        @(negedge clk); evt = 12'h040; cause = 13'h0020; rd_en = 1; addr = 5'd22;
        @(negedge clk); evt = '0; cause = '0; rd_en = 0;
        rd(3, d); chk("R8 new cause survives clear", d, 16'h0020);
        rd(4, d);
        rd(3, d); chk("R7 combined clear empties cause", d, 16'h0);

        // R11 transfer start priority
        @(negedge clk); xstart = 1; wr_en = 1; addr = 5'd1; wdata = 16'h0FFF;
        @(negedge clk); xstart = 0; wr_en = 0;
        rd(1, d); chk("R11 transfer mask", d, 16'h0254);

        // R1 reset again clears everything
        pulse(12'h201, 13'h0);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd(0, d); chk("R1 raw after reset", d, 16'h0);
        chk("R1 irq after reset", 16'(irq), 16'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule